// File: doc/BRIEF.md
# Shared Two-Way Byte Buffer with Word Packing

This block is a 64-byte buffer that sits between a host bus and a memory-card data path. It carries data one way at a time. In the card-to-host direction, the card side writes single bytes and the host reads 32-bit words. In the host-to-card direction, the host writes 32-bit words and the card side reads single bytes. Words are packed and unpacked little-endian: bits 7:0 are the byte that is earliest in the buffer.

The block raises a level DMA request while enough data can be moved. In the card-to-host direction that means enough bytes are held. In the host-to-card direction it means enough bytes are free. The threshold is 16 or 32 bytes. An interrupt flag is set when that condition becomes true and stays set until software clears it. Changing the direction, or pulsing flush, empties the buffer and drops a pending interrupt.

Top module: `xbf_top`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `irq`=0 and `dma_req`=0. The direction is card-to-host (`to_card`=0).
- R2: With `to_card`=1 (host-to-card), a host word is accepted only when at least 4 bytes are free (`host_wr_ready`=1). `card_rd_valid` is high whenever data is held. The card side reads the word's bytes in the order bits 7:0, 15:8, 23:16, 31:24.
- R3: With `to_card`=0 (card-to-host), a card byte is accepted only when the buffer is not full (`card_wr_ready`=1). A host word read is offered only when at least 4 bytes are held (`host_rd_ready`=1). `host_rd_data` carries the oldest byte in bits 7:0 and the fourth-oldest byte in bits 31:24.
- R4: `full` is high exactly when 64 bytes are held, and `empty` is high exactly when none are held.
- R5: Enables that belong to the other direction have no effect on the stored data or on the flags.
- R6: With `to_card`=0, `dma_req` is high while the bytes held are at least the threshold: 16 when `thr_sel`=0, 32 when `thr_sel`=1.
- R7: With `to_card`=1, `dma_req` is high while the bytes free are at least the same threshold.
- R8: `irq` sets one cycle after `dma_req` goes from low to high. It stays set until a cycle with `irq_clr`=1. A new setting event in the same cycle as `irq_clr` wins over the clear.
- R9: In a cycle where `flush`=1, or where `to_card` differs from the current direction, all transfers in that cycle are ignored and all ready and valid outputs are low. At the next edge the buffer empties, `irq` clears and the new direction takes effect.
- R10: A push and a pop in the same cycle are both applied, and the byte count changes by the difference between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| to_card | input | 1 | Direction: 1 host-to-card, 0 card-to-host |
| flush | input | 1 | Empty the buffer and clear the interrupt |
| thr_sel | input | 1 | Threshold: 0 selects 16 bytes, 1 selects 32 bytes |
| irq_clr | input | 1 | Clear the interrupt flag |
| host_wr_en | input | 1 | Host writes one word |
| host_wr_data | input | 32 | Host write word |
| host_wr_ready | output | 1 | A host word can be written |
| host_rd_en | input | 1 | Host reads one word |
| host_rd_data | output | 32 | Oldest four bytes, packed little-endian |
| host_rd_ready | output | 1 | A host word can be read |
| card_wr_en | input | 1 | Card side writes one byte |
| card_wr_data | input | 8 | Card write byte |
| card_wr_ready | output | 1 | A card byte can be written |
| card_rd_en | input | 1 | Card side reads one byte |
| card_rd_data | output | 8 | Oldest byte |
| card_rd_valid | output | 1 | A card byte can be read |
| full | output | 1 | 64 bytes held |
| empty | output | 1 | No bytes held |
| dma_req | output | 1 | Threshold condition, level |
| irq | output | 1 | Sticky threshold interrupt |

## Verification
Directed fill and drain runs in each direction take the count through both thresholds and both end points. They show whether the threshold is measured on held bytes or on free bytes, and whether pushes at full or pops at empty are blocked. Back-to-back word pushes against byte pops, and byte pushes against word pops, separate the right lane order from a byte-swapped one. The same pattern also shows whether a push and a pop in one cycle are both counted. A long random phase asserts every enable in both directions and, now and then, flush, direction changes, threshold changes and interrupt clears. Compared each cycle against a queue model, it shows whether enables for the other direction leak in and whether a clear loses a setting event.

// File: rtl/xbf_pkg.sv
package xbf_pkg;
  localparam int WORD_BYTES = 4;

  typedef enum logic {
    DIR_TO_HOST = 1'b0,
    DIR_TO_CARD = 1'b1
  } xdir_e;

  // byte lane i of a host word, lane 0 = bits 7:0 (first in the buffer)
  function automatic logic [7:0] lane_byte(input logic [31:0] w, input int i);
    return w[8*i +: 8];
  endfunction

  // threshold in bytes for the select input
  function automatic int thr_bytes(input logic sel, input int lo, input int hi);
    return sel ? hi : lo;
  endfunction

  // whether the moving side has a threshold's worth to move
  function automatic logic thr_met(input xdir_e dir, input int held, input int room, input int thr);
    return (dir == DIR_TO_CARD) ? (room >= thr) : (held >= thr);
  endfunction
endpackage

// File: rtl/xbf_store.sv
module xbf_store
  import xbf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr_word,
  input  logic        wr_byte,
  input  logic [31:0] wr_wdata,
  input  logic [7:0]  wr_bdata,
  input  logic        rd_word,
  input  logic        rd_byte,
  output logic [31:0] rd_wdata,
  output logic [7:0]  rd_bdata
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;

  always_ff @(posedge clk) begin
    if (wr_word) begin
      for (int i = 0; i < WORD_BYTES; i++) begin
        mem[wptr + AW'(i)] <= lane_byte(wr_wdata, i);
      end
    end else if (wr_byte) begin
      mem[wptr] <= wr_bdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_word)      wptr <= wptr + AW'(WORD_BYTES);
      else if (wr_byte) wptr <= wptr + AW'(1);
      if (rd_word)      rptr <= rptr + AW'(WORD_BYTES);
      else if (rd_byte) rptr <= rptr + AW'(1);
    end
  end

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign rd_wdata[8*g +: 8] = mem[rptr + AW'(g)];
  end

  assign rd_bdata = mem[rptr];
endmodule

// File: rtl/xbf_level.sv
module xbf_level #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [2:0]    push_n,
  input  logic [2:0]    pop_n,
  output logic [CW-1:0] count,
  output logic [CW-1:0] room,
  output logic          full,
  output logic          empty
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) count <= '0;
    else               count <= count + CW'(push_n) - CW'(pop_n);
  end

  assign room  = CW'(DEPTH) - count;
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/xbf_event.sv
module xbf_event
  import xbf_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CW     = $clog2(DEPTH) + 1,
  parameter int THR_LO = 16,
  parameter int THR_HI = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  xdir_e         dir,
  input  logic          thr_sel,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] room,
  input  logic          irq_clr,
  output logic          dma_req,
  output logic          thr_rise,
  output logic          irq
);
  logic cond_q;

  assign dma_req  = thr_met(dir, int'(count), int'(room), thr_bytes(thr_sel, THR_LO, THR_HI));
  assign thr_rise = dma_req && !cond_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cond_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      cond_q <= dma_req;
      irq    <= thr_rise || (irq && !irq_clr);
    end
  end
endmodule

// File: rtl/xbf_top.sv
module xbf_top
  import xbf_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int THR_LO = 16,
  parameter int THR_HI = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        to_card,
  input  logic        flush,
  input  logic        thr_sel,
  input  logic        irq_clr,
  input  logic        host_wr_en,
  input  logic [31:0] host_wr_data,
  output logic        host_wr_ready,
  input  logic        host_rd_en,
  output logic [31:0] host_rd_data,
  output logic        host_rd_ready,
  input  logic        card_wr_en,
  input  logic [7:0]  card_wr_data,
  output logic        card_wr_ready,
  input  logic        card_rd_en,
  output logic [7:0]  card_rd_data,
  output logic        card_rd_valid,
  output logic        full,
  output logic        empty,
  output logic        dma_req,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  xdir_e         dir_q;
  logic          dir_chg;
  logic          clr;
  logic [CW-1:0] count;
  logic [CW-1:0] room;
  logic          word_in, byte_in, word_out, byte_out;
  logic [2:0]    push_n, pop_n;
  logic          thr_rise;

  assign dir_chg = (xdir_e'(to_card) != dir_q);
  assign clr     = flush || dir_chg;

  always_ff @(posedge clk) begin
    if (!rst_n)  dir_q <= DIR_TO_HOST;
    else if (clr) dir_q <= xdir_e'(to_card);
  end

  assign host_wr_ready = !clr && (dir_q == DIR_TO_CARD) && (int'(room) >= WORD_BYTES);
  assign card_rd_valid = !clr && (dir_q == DIR_TO_CARD) && !empty;
  assign card_wr_ready = !clr && (dir_q == DIR_TO_HOST) && !full;
  assign host_rd_ready = !clr && (dir_q == DIR_TO_HOST) && (int'(count) >= WORD_BYTES);

  assign word_in  = host_wr_en && host_wr_ready;
  assign byte_out = card_rd_en && card_rd_valid;
  assign byte_in  = card_wr_en && card_wr_ready;
  assign word_out = host_rd_en && host_rd_ready;

  assign push_n = word_in  ? 3'(WORD_BYTES) : (byte_in  ? 3'd1 : 3'd0);
  assign pop_n  = word_out ? 3'(WORD_BYTES) : (byte_out ? 3'd1 : 3'd0);

  xbf_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .wr_word  (word_in),
    .wr_byte  (byte_in),
    .wr_wdata (host_wr_data),
    .wr_bdata (card_wr_data),
    .rd_word  (word_out),
    .rd_byte  (byte_out),
    .rd_wdata (host_rd_data),
    .rd_bdata (card_rd_data)
  );

  xbf_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .push_n (push_n),
    .pop_n  (pop_n),
    .count  (count),
    .room   (room),
    .full   (full),
    .empty  (empty)
  );

  xbf_event #(.DEPTH(DEPTH), .CW(CW), .THR_LO(THR_LO), .THR_HI(THR_HI)) u_event (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .dir      (dir_q),
    .thr_sel  (thr_sel),
    .count    (count),
    .room     (room),
    .irq_clr  (irq_clr),
    .dma_req  (dma_req),
    .thr_rise (thr_rise),
    .irq      (irq)
  );
endmodule

// File: rtl/xbf_chk.sv
module xbf_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic [CW-1:0] count,
  input logic          full,
  input logic          empty,
  input logic          dma_req,
  input logic          irq,
  input logic          irq_clr
);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_flags_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !irq));

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr && !clr) |=> irq);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(dma_req));
endmodule

bind xbf_top xbf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr     (clr),
  .count   (count),
  .full    (full),
  .empty   (empty),
  .dma_req (dma_req),
  .irq     (irq),
  .irq_clr (irq_clr)
);

// File: tb/sim_xbf_top.sv
module sim_xbf_top;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        to_card = 1'b0, flush = 1'b0, thr_sel = 1'b0, irq_clr = 1'b0;
  logic        host_wr_en = 1'b0, host_rd_en = 1'b0, card_wr_en = 1'b0, card_rd_en = 1'b0;
  logic [31:0] host_wr_data = '0;
  logic [7:0]  card_wr_data = '0;
  logic        host_wr_ready, host_rd_ready, card_wr_ready, card_rd_valid;
  logic [31:0] host_rd_data;
  logic [7:0]  card_rd_data;
  logic        full, empty, dma_req, irq;

  always #5 clk = ~clk;

  xbf_top u0 (
    .clk(clk), .rst_n(rst_n), .to_card(to_card), .flush(flush), .thr_sel(thr_sel),
    .irq_clr(irq_clr), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_wr_ready(host_wr_ready), .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
    .host_rd_ready(host_rd_ready), .card_wr_en(card_wr_en), .card_wr_data(card_wr_data),
    .card_wr_ready(card_wr_ready), .card_rd_en(card_rd_en), .card_rd_data(card_rd_data),
    .card_rd_valid(card_rd_valid), .full(full), .empty(empty), .dma_req(dma_req), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit running = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: a byte queue plus three flags
  logic [7:0] q[$];
  bit dir_m = 1'b0, cond_m = 1'b0, irq_m = 1'b0;
  bit prev_both = 1'b0, prev_wrong = 1'b0;
  bit clr_m, c_now, push_m, pop_m;
  int sz;

  function automatic bit cond_f();
    int thr = thr_sel ? 32 : 16;
    return dir_m ? ((DEPTH - q.size()) >= thr) : (q.size() >= thr);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); dir_m = 1'b0; cond_m = 1'b0; irq_m = 1'b0;
      prev_both = 1'b0; prev_wrong = 1'b0;
    end else begin
      clr_m = flush || (to_card != dir_m);
      if (clr_m) begin
        q.delete(); irq_m = 1'b0; cond_m = 1'b0; dir_m = to_card;
        prev_both = 1'b0; prev_wrong = 1'b0;
      end else begin
        c_now  = cond_f();
        irq_m  = (irq_m && !irq_clr) || (c_now && !cond_m);
        cond_m = c_now;
        sz = q.size();
        if (dir_m) begin
          push_m = host_wr_en && (DEPTH - sz) >= 4;
          pop_m  = card_rd_en && sz > 0;
          prev_wrong = card_wr_en || host_rd_en;
          if (pop_m) void'(q.pop_front());
          if (push_m) for (int k = 0; k < 4; k++) q.push_back(host_wr_data[8*k +: 8]);
        end else begin
          push_m = card_wr_en && sz < DEPTH;
          pop_m  = host_rd_en && sz >= 4;
          prev_wrong = host_wr_en || card_rd_en;
          if (pop_m) for (int k = 0; k < 4; k++) void'(q.pop_front());
          if (push_m) q.push_back(card_wr_data);
        end
        prev_both = push_m && pop_m;
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      bit xc;
      int n;
      xc = flush || (to_card != dir_m);
      n  = q.size();
      chk(prev_both ? "R10 full" : "R4 full", 32'(full), 32'(n == DEPTH));
      chk(prev_both ? "R10 empty" : (prev_wrong ? "R5 empty" : "R4 empty"), 32'(empty), 32'(n == 0));
      chk(dir_m ? "R7 dma_req" : "R6 dma_req", 32'(dma_req), 32'(cond_f()));
      chk("R8 irq", 32'(irq), 32'(irq_m));
      chk(xc ? "R9 host_wr_ready" : "R2 host_wr_ready", 32'(host_wr_ready), 32'(!xc && dir_m && (DEPTH - n) >= 4));
      chk(xc ? "R9 card_rd_valid" : "R2 card_rd_valid", 32'(card_rd_valid), 32'(!xc && dir_m && n > 0));
      chk(xc ? "R9 card_wr_ready" : "R3 card_wr_ready", 32'(card_wr_ready), 32'(!xc && !dir_m && n < DEPTH));
      chk(xc ? "R9 host_rd_ready" : "R3 host_rd_ready", 32'(host_rd_ready), 32'(!xc && !dir_m && n >= 4));
      if (dir_m && n > 0)
        chk(prev_wrong ? "R5 card_rd_data" : "R2 card_rd_data", 32'(card_rd_data), 32'(q[0]));
      if (!dir_m && n >= 4)
        chk(prev_wrong ? "R5 host_rd_data" : "R3 host_rd_data", host_rd_data, {q[3], q[2], q[1], q[0]});
    end
  end

  task automatic cyc(input bit hw, input bit hr, input bit cw, input bit cr);
    @(posedge clk); #2;
    host_wr_en = hw; host_rd_en = hr; card_wr_en = cw; card_rd_en = cr;
    host_wr_data = $urandom; card_wr_data = 8'($urandom);
    irq_clr = 1'b0; flush = 1'b0;
  endtask

  task automatic do_flush();
    @(posedge clk); #2;
    host_wr_en = 1'b1; card_wr_en = 1'b1; flush = 1'b1; irq_clr = 1'b0;
    @(posedge clk); #2;
    flush = 1'b0; host_wr_en = 1'b0; card_wr_en = 1'b0;
    @(negedge clk);
    chk("R9 empty after flush", 32'(empty), 32'd1);
    chk("R9 irq after flush", 32'(irq), 32'd0);
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 empty", 32'(empty), 32'd1);
    chk("R1 full", 32'(full), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 dma_req", 32'(dma_req), 32'd0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    running = 1'b1;

    // card-to-host: fill past full, drain with word reads
    repeat (80) cyc(0, 0, 1, 0);
    @(posedge clk); #2; irq_clr = 1'b1;
    repeat (20) cyc(0, 1, 0, 0);
    repeat (30) cyc(0, 1, 1, 0);
    thr_sel = 1'b1;
    repeat (70) cyc(0, 0, 1, 0);
    repeat (20) cyc(1, 1, 1, 1);
    do_flush();

    // host-to-card: word writes, byte reads
    to_card = 1'b1;
    repeat (2) cyc(0, 0, 0, 0);
    repeat (20) cyc(1, 0, 0, 0);
    repeat (70) cyc(0, 0, 0, 1);
    thr_sel = 1'b0;
    repeat (40) cyc(1, 0, 0, 1);
    repeat (10) cyc(1, 0, 0, 0);
    do_flush();
    to_card = 1'b0;

    // random mix
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk); #2;
      host_wr_en = ($urandom % 2) == 0;
      host_rd_en = ($urandom % 3) == 0;
      card_wr_en = ($urandom % 2) == 0;
      card_rd_en = ($urandom % 3) == 0;
      host_wr_data = $urandom;
      card_wr_data = 8'($urandom);
      irq_clr = ($urandom % 16) == 0;
      flush   = ($urandom % 250) == 0;
      if (($urandom % 300) == 0) to_card = ~to_card;
      if (($urandom % 120) == 0) thr_sel = ~thr_sel;
    end
    cyc(0, 0, 0, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    running = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule